// File: doc/BRIEF.md
# Prescaled PWM Timer with Register Access

This block produces one pulse-width-modulated output from two memory-mapped registers. A control word holds the run enable, an update-hold bit and a power-of-two clock divider. The divider is given as a coarse 4-bit field plus a half-step bit, so the exponent is d = 2*coarse + half. A count word holds a 10-bit period and a 10-bit high time, both in prescaled ticks. While running, the output is high for the first `high` ticks of every period and low for the rest.

Software that must change period, high time and divider together first sets the hold bit. Writes made while it is set are staged, and reads still return the values in force. Clearing the bit moves every staged value into force in one cycle. A running waveform picks up new values only at its next period boundary, so no cycle is ever cut short. A period or high time of zero is not allowed. The enable refuses to set while either value is zero. A divider exponent above the `PRESC_MAX` parameter is limited to that value.

Top module: `pwm_timer_regs`

## Requirements
- R1: After reset both registers read as zero and `pwm_out` is low.
- R2: The control register is at address 0x0, with enable at bit 0, hold at bit 11, half-step at bit 15 and the coarse divider at bits 19:16. The divider is 2^(2*coarse+half). A read strobe returns its data on `bus_rdata` one cycle later.
- R3: The count register is at address 0x4, with the period at bits 25:16 and the high time at bits 9:0. Bits of either register that are not named in R2 or R3 read as zero and are ignored on write.
- R4: With enable written to 1 at a clock edge, `pwm_out` is high from the next edge for high*2^d cycles and low for the rest of a period of period*2^d cycles. It then repeats.
- R5: When the high time is greater than or equal to the period, `pwm_out` stays high for the whole period.
- R6: The enable bit does not set, and reads back as 0 with `pwm_out` low, while the period or high time in force is zero. Putting a zero into force while running clears the enable.
- R7: While hold is 1, writes to period, high time and divider are staged and reads return the values in force. The write that clears hold puts all staged values into force at once. The divider field of that clearing write is ignored in favour of the staged one.
- R8: Values put into force while running take effect at the next period boundary. The period in progress completes with the old high time and length.
- R9: Writing enable to 0 drives `pwm_out` low from the second edge after the write. Both registers stay readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pwm_out | output | 1 | PWM output |

## Verification
A register write takes effect at the edge that samples it. `pwm_out` responds one edge later, because the output is registered from the counter. Read data appears one edge after the read strobe. The bench drives every access on a falling edge and samples on the next falling edge after the capturing rising edge. It then counts waveform samples on falling edges: from the first edge after an enable write, high runs are expected to last exactly high*2^d samples and periods exactly period*2^d samples. Boundary behaviour is checked with run lengths measured from a detected rising edge, so the completing old period and the first new period are compared cycle by cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 4;
  localparam int CNT_W        = 10;
  localparam int DIV_W        = 5;
  localparam int PRESC_MAX_DEF = 24;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h4;

  // bit positions decoded by software
  localparam int CTL_EN     = 0;
  localparam int CTL_HOLD   = 11;
  localparam int CTL_HALF   = 15;
  localparam int CTL_COARSE = 16;
  localparam int CNT_PER    = 16;
  localparam int CNT_HIGH   = 0;

  typedef struct packed {
    logic [DIV_W-1:0] div;   // exponent: {coarse, half}
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] high;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_en,
  output logic              hold_o,
  output pwm_cfg_t          cfg_q_o,
  output pwm_cfg_t          cfg_next
);
  logic              en_q, en_d;
  logic              hold_q, hold_d;
  pwm_cfg_t          stg_q, stg_d;
  pwm_cfg_t          com_q, com_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_val;
  logic              wr_ctrl, wr_cnt, rd_acc;
  logic [DIV_W-1:0]  w_div;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;

  always_comb begin
    wr_ctrl = bus_sel && bus_we && (bus_addr == OFS_CTRL);
    wr_cnt  = bus_sel && bus_we && (bus_addr == OFS_CNT);
    rd_acc  = bus_sel && !bus_we;
    w_div   = {bus_wdata[CTL_COARSE +: DIV_W-1], bus_wdata[CTL_HALF]};

    stg_d = stg_q;
    if (wr_cnt) begin
      stg_d.per  = bus_wdata[CNT_PER  +: CNT_W];
      stg_d.high = bus_wdata[CNT_HIGH +: CNT_W];
    end
    // a write that releases the hold keeps the staged divider
    if (wr_ctrl && !(hold_q && !bus_wdata[CTL_HOLD]))
      stg_d.div = w_div;

    hold_d = wr_ctrl ? bus_wdata[CTL_HOLD] : hold_q;
    com_d  = hold_d ? com_q : stg_d;
    en_d   = (wr_ctrl ? bus_wdata[CTL_EN] : en_q) && (|com_d.per) && (|com_d.high);

    rd_val = '0;
    if (bus_addr == OFS_CTRL) begin
      rd_val[CTL_COARSE +: DIV_W-1] = com_q.div[DIV_W-1:1];
      rd_val[CTL_HALF]              = com_q.div[0];
      rd_val[CTL_HOLD]              = hold_q;
      rd_val[CTL_EN]                = en_q;
    end else if (bus_addr == OFS_CNT) begin
      rd_val[CNT_PER  +: CNT_W] = com_q.per;
      rd_val[CNT_HIGH +: CNT_W] = com_q.high;
    end
    rdata_d = rd_acc ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      hold_q  <= 1'b0;
      stg_q   <= '0;
      com_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      hold_q  <= hold_d;
      stg_q   <= stg_d;
      com_q   <= com_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign run_en    = en_q;
  assign hold_o    = hold_q;
  assign cfg_q_o   = com_q;
  assign cfg_next  = com_d;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int PRESC_MAX = PRESC_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PRESC_MAX-1:0] pre_q, pre_d, mask;
  logic [DIV_W-1:0]     d_eff;

  always_comb begin
    d_eff = (div > DIV_W'(PRESC_MAX)) ? DIV_W'(PRESC_MAX) : div;
    for (int i = 0; i < PRESC_MAX; i++)
      mask[i] = (DIV_W'(i) < d_eff);
    tick  = ((pre_q & mask) == mask);
    pre_d = clr ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  pwm_cfg_t         cfg_next,
  input  logic             tick,
  output logic             wrap,
  output logic [DIV_W-1:0] act_div,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_per_o,
  output logic             pwm
);
  pwm_cfg_t         act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwm_q, pwm_d;
  logic             last;

  always_comb begin
    last  = (cnt_q == act_q.per - 1'b1);
    wrap  = run_en && tick && last;
    act_d = act_q;
    cnt_d = cnt_q;
    if (!run_en) begin
      act_d = cfg_next;
      cnt_d = '0;
    end else if (tick) begin
      if (last) begin
        cnt_d = '0;
        act_d = cfg_next;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    pwm_d = run_en && (cnt_q < act_q.high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign act_div   = act_q.div;
  assign cnt_o     = cnt_q;
  assign act_per_o = act_q.per;
  assign pwm       = pwm_q;
endmodule

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int PRESC_MAX = PRESC_MAX_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic             run_en, hold_st, tick, wrap;
  pwm_cfg_t         com_cfg, cfg_next;
  logic [DIV_W-1:0] act_div;
  logic [CNT_W-1:0] cnt_val, act_per;

  pwm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run_en(run_en), .hold_o(hold_st), .cfg_q_o(com_cfg), .cfg_next(cfg_next)
  );

  pwm_prescaler #(.PRESC_MAX(PRESC_MAX)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(!run_en || wrap), .div(act_div), .tick(tick)
  );

  pwm_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_next(cfg_next),
    .tick(tick), .wrap(wrap), .act_div(act_div), .cnt_o(cnt_val),
    .act_per_o(act_per), .pwm(pwm_out)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic              run_en,
  input logic              hold_st,
  input pwm_cfg_t          com_cfg,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  act_per,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] USED_BITS = 32'h03FF_8BFF;

  // R9: output is low once enable has been clear for a cycle
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !pwm_out);

  // R6: enable only with nonzero period and high time in force
  p_en_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> ((|com_cfg.per) && (|com_cfg.high)));

  // R7: values in force do not move while hold stays set
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_st |=> (!hold_st || $stable(com_cfg)));

  // R4: counter stays inside the active period
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (cnt_val < act_per));

  // R4: first output cycle after start is high
  p_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> pwm_out);

  // R3: unnamed bits never read back
  p_rdata_unused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~USED_BITS) == '0);
endmodule

bind pwm_timer_regs pwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .run_en(run_en),
  .hold_st(hold_st), .com_cfg(com_cfg), .cnt_val(cnt_val),
  .act_per(act_per), .bus_rdata(bus_rdata)
);

// File: tb/sim_pwm_timer_regs.sv
`timescale 1ns/1ps
module sim_pwm_timer_regs;
  import pwm_timer_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk;
  int n_fail;

  // {div[63:56], period[55:40], high[39:24], exp_high[23:12], exp_period[11:0]}
  localparam logic [63:0] VEC [6] = '{
    {8'd0, 16'd10, 16'd3, 12'd3,  12'd10},
    {8'd1, 16'd5,  16'd2, 12'd4,  12'd10},
    {8'd2, 16'd4,  16'd1, 12'd4,  12'd16},
    {8'd3, 16'd3,  16'd3, 12'd24, 12'd24},
    {8'd0, 16'd6,  16'd9, 12'd6,  12'd6},
    {8'd4, 16'd2,  16'd1, 12'd16, 12'd32}
  };

  pwm_timer_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [4:0] d, input logic en, input logic hold);
    logic [31:0] w;
    w = '0;
    w[19:16] = d[4:1];
    w[15]    = d[0];
    w[11]    = hold;
    w[0]     = en;
    return w;
  endfunction

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    logic prev;
    prev = pwm_out;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin
        ok = 1'b1;
        return;
      end
      prev = pwm_out;
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pwm_out === lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int hi, lo, cnt1;
    bit ok;
    n_chk = 0; n_fail = 0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 output after reset", 32'(pwm_out), 32'd0);
    bread(OFS_CTRL, rd); check("R1 control reads zero", rd, 32'h0);
    bread(OFS_CNT, rd);  check("R1 count reads zero", rd, 32'h0);

    // R2 R4 R5 vector walk
    for (int v = 0; v < 6; v++) begin
      logic [4:0] dv;
      int cyc, ph, eh, ep, first;
      dv  = VEC[v][60:56];
      cyc = int'(VEC[v][55:40]);
      ph  = int'(VEC[v][39:24]);
      eh  = int'(VEC[v][23:12]);
      ep  = int'(VEC[v][11:0]);
      bwrite(OFS_CTRL, 32'h0);
      bwrite(OFS_CNT, (32'(cyc) << 16) | 32'(ph));
      bwrite(OFS_CTRL, ctrl_word(dv, 1'b1, 1'b0));
      hi = 0; first = 0;
      for (int k = 0; k < ep; k++) begin
        @(negedge clk);
        if (k == 0) first = int'(pwm_out);
        hi = hi + int'(pwm_out);
      end
      check($sformatf("R4 vector %0d first cycle high", v), 32'(first), 32'd1);
      check($sformatf("R2 R4 R5 vector %0d high cycles per period", v), 32'(hi), 32'(eh));
      @(negedge clk);
      check($sformatf("R2 R4 vector %0d next period starts", v), 32'(pwm_out), 32'd1);
    end

    // R9 disable drives output low, registers still usable
    bwrite(OFS_CTRL, ctrl_word(5'd4, 1'b0, 1'b0));
    @(negedge clk);
    check("R9 output low after disable", 32'(pwm_out), 32'd0);
    cnt1 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cnt1 = cnt1 + int'(pwm_out);
    end
    check("R9 output stays low", 32'(cnt1), 32'd0);
    bread(OFS_CNT, rd); check("R9 count readable while stopped", rd, 32'h0002_0001);

    // R3 unused bits
    bwrite(OFS_CNT, 32'hFFFF_FFFF);
    bread(OFS_CNT, rd); check("R3 count unused bits", rd, 32'h03FF_03FF);
    bwrite(OFS_CTRL, 32'hFFFF_F7FE);
    bread(OFS_CTRL, rd); check("R2 R3 control unused bits", rd, 32'h000F_8000);

    // R6 refused enable
    bwrite(OFS_CTRL, 32'h0);
    bwrite(OFS_CNT, 32'h0000_0005);
    bwrite(OFS_CTRL, 32'h1);
    bread(OFS_CTRL, rd); check("R6 enable refused with zero period", rd, 32'h0);
    cnt1 = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cnt1 = cnt1 + int'(pwm_out);
    end
    check("R6 output low with zero period", 32'(cnt1), 32'd0);
    bwrite(OFS_CNT, 32'h0005_0000);
    bwrite(OFS_CTRL, 32'h1);
    bread(OFS_CTRL, rd); check("R6 enable refused with zero high time", rd, 32'h0);
    bwrite(OFS_CNT, 32'h0005_0002);
    bwrite(OFS_CTRL, 32'h1);
    bread(OFS_CTRL, rd); check("R6 enable accepted with nonzero values", rd, 32'h1);
    repeat (10) @(negedge clk);
    bwrite(OFS_CNT, 32'h0000_0002);
    bread(OFS_CTRL, rd); check("R6 zero period clears enable", rd, 32'h0);
    @(negedge clk);
    check("R6 output low after zero commit", 32'(pwm_out), 32'd0);

    // R7 R8 hold, staging and boundary update
    bwrite(OFS_CTRL, 32'h0);
    bwrite(OFS_CNT, 32'h000A_0003);
    bwrite(OFS_CTRL, 32'h1);
    bwrite(OFS_CTRL, ctrl_word(5'd0, 1'b1, 1'b1));
    bwrite(OFS_CNT, 32'h0008_0005);
    bwrite(OFS_CTRL, ctrl_word(5'd1, 1'b1, 1'b1));
    bread(OFS_CNT, rd);  check("R7 count reads values in force", rd, 32'h000A_0003);
    bread(OFS_CTRL, rd); check("R7 control reads divider in force", rd, 32'h0000_0801);
    wait_rise(ok);
    check("R8 rising edge found", 32'(ok), 32'd1);
    // release hold on the edge after the period start; divider field 0 must be ignored
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = 32'h1;
    hi = 1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    while (pwm_out && hi < 500) begin
      hi++;
      @(negedge clk);
    end
    check("R8 old period high completes", 32'(hi), 32'd3);
    run_len(1'b0, lo); check("R8 old period low completes", 32'(lo), 32'd7);
    run_len(1'b1, hi); check("R7 R8 new high time with staged divider", 32'(hi), 32'd10);
    run_len(1'b0, lo); check("R7 R8 new low time with staged divider", 32'(lo), 32'd6);
    bread(OFS_CTRL, rd); check("R7 staged divider in force", rd, 32'h0000_8001);
    bread(OFS_CNT, rd);  check("R7 staged count in force", rd, 32'h0008_0005);

    finish_run();
  end
endmodule